// File: doc/BRIEF.md
# Bit-Serial In-Memory Adder Sequencer

This block runs an N-bit addition of two rows of a memory array whose sense path can report, for one column, the OR, the majority and the AND of three rows that are activated together. It works from the least significant column upward. At each bit it activates the A row, the B row and a scratch carry row in the same column and waits for the logic unit to answer. It then forms the sum bit from the three answers alone and writes the sum bit into the result row. The majority answer is the carry-out, and it goes back to the carry row one column higher so that the next step can sense it.

Software or a higher-level sequencer supplies four row addresses and pulses `start`. The block first clears the carry row's column 0. When the last column has been written it pulses `done` and reports the final carry-out. A parameter sets the number of cycles the logic unit takes to answer. A one-cycle unit gives two cycles per bit, and a three-cycle unit gives four.

Top module: `imadd_ctrl`

## Requirements
- R1: Each bit step makes exactly one activation. It carries the latched A, B and carry rows and the column equal to that step's bit index, counting from 0. The function mask `actFn` is 3'b111 (bit 0 OR, bit 1 MAJ, bit 2 AND).
- R2: The sum bit is AND | (OR & ~MAJ), built only from the logic unit's answers. It is written to the result row at the column of the current bit.
- R3: The carry-out of bit i is the MAJ answer. It is written to the carry row at column i+1, in the same cycle as the sum write of bit i.
- R4: An N-bit addition makes exactly N-1 carry write-backs. No carry is written after the most significant bit.
- R5: Before the first activation, the carry row's column 0 is written with 0. This is the only carry write to column 0 in a run.
- R6: Sum and carry are written in the cycle LAT cycles after the activation cycle, so a bit step lasts LAT+1 cycles.
- R7: `done` is a one-cycle pulse. It becomes visible after the (2 + N*(LAT+1))-th rising edge, counting the edge that samples `start` as the first. `carryOut` then holds the MAJ of the most significant bit until the next accepted start.
- R8: `start` has no effect while an addition is in progress. The result and the run length are unchanged.
- R9: During reset, `done`, `actReq`, both write enables and `carryOut` are 0.
- R10: After a run, the result row holds (A + B) mod 2^N and `carryOut` holds bit N of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition (sampled while idle) |
| rowA | input | RW | Row of operand A |
| rowB | input | RW | Row of operand B |
| rowCarry | input | RW | Scratch row for carries |
| rowSum | input | RW | Row receiving the sum |
| done | output | 1 | One-cycle completion pulse |
| carryOut | output | 1 | Final carry-out of the last run |
| actReq | output | 1 | Three-row activation request |
| actFn | output | 3 | Requested sense functions {AND, MAJ, OR} |
| actRowA | output | RW | First activated row |
| actRowB | output | RW | Second activated row |
| actRowC | output | RW | Third activated row (carry) |
| actCol | output | CW | Column being sensed |
| luOr | input | 1 | OR answer of the logic unit |
| luMaj | input | 1 | Majority answer of the logic unit |
| luAnd | input | 1 | AND answer of the logic unit |
| wrSumEn | output | 1 | Sum bit write enable |
| wrSumRow | output | RW | Sum write row |
| wrSumCol | output | CW | Sum write column |
| wrSumBit | output | 1 | Sum bit value |
| wrCarryEn | output | 1 | Carry bit write enable |
| wrCarryRow | output | RW | Carry write row |
| wrCarryCol | output | CW | Carry write column |
| wrCarryBit | output | 1 | Carry bit value |

## Verification
The case hardest to reach from the ports is a carry row holding stale ones. If the clear before bit 0 were missing, or a carry were written to the wrong column, a zero-carry sum would still come out right whenever the row happened to be clean. Before every run the bench therefore fills the carry row and the result row with ones. It checks the whole carry row afterwards against the carries it computes from the operands. It also uses operand pairs that ripple a carry through every column (all ones plus one, all ones plus all ones). A second instance with a three-cycle logic unit exercises the wait path, and a start pulse injected mid-run probes the busy guard.

// File: rtl/imadd_pkg.sv
package imadd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ACT,
    ST_EVAL,
    ST_WRITE,
    ST_DONE
  } stepState_t;

  typedef struct packed {
    logic capture;     // latch row addresses, clear final carry
    logic clearCarry;  // write 0 into carry column 0
    logic activate;    // three-row activation this cycle
    logic writeBack;   // logic answers valid, write sum / carry
    logic lastBit;     // current bit is the most significant one
  } ctrlStrobe_t;

endpackage

// File: rtl/imadd_seq.sv
module imadd_seq
  import imadd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LAT   = 1,
  localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output ctrlStrobe_t   strobe,
  output logic [CW-1:0] bitIdx,
  output logic          done
);

  localparam int LCW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  stepState_t state;
  logic       waitDone;
  logic       isLast;

  assign isLast = (bitIdx == LAST_IDX);

  generate
    if (LAT > 1) begin : g_wait
      logic [LCW-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          waitCnt <= '0;
        end else if (state == ST_ACT) begin
          waitCnt <= LCW'(LAT - 1);
        end else if (state == ST_EVAL) begin
          waitCnt <= waitCnt - 1'b1;
        end
      end
      assign waitDone = (waitCnt == LCW'(1));
    end else begin : g_nowait
      assign waitDone = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_CLEAR;
        ST_CLEAR: begin
          bitIdx <= '0;
          state  <= ST_ACT;
        end
        ST_ACT:   state <= (LAT == 1) ? ST_WRITE : ST_EVAL;
        ST_EVAL:  if (waitDone) state <= ST_WRITE;
        ST_WRITE: begin
          if (isLast) begin
            state <= ST_DONE;
          end else begin
            bitIdx <= bitIdx + 1'b1;
            state  <= ST_ACT;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.capture    = (state == ST_IDLE) && start;
    strobe.clearCarry = (state == ST_CLEAR);
    strobe.activate   = (state == ST_ACT);
    strobe.writeBack  = (state == ST_WRITE);
    strobe.lastBit    = isLast;
  end

  assign done = (state == ST_DONE);

  AST_WRITE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> ($past(state) == ST_ACT || $past(state) == ST_EVAL)); // R6

  AST_CLEAR_BEFORE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && bitIdx == '0) |-> ($past(state) == ST_CLEAR)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACT || state == ST_EVAL || state == ST_WRITE) && start)
      |=> (state != ST_CLEAR)); // R8

endmodule

// File: rtl/imadd_dp.sv
module imadd_dp
  import imadd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int RW    = 4,
  localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [CW-1:0] bitIdx,
  input  logic [RW-1:0] rowA,
  input  logic [RW-1:0] rowB,
  input  logic [RW-1:0] rowCarry,
  input  logic [RW-1:0] rowSum,
  input  logic          luOr,
  input  logic          luMaj,
  input  logic          luAnd,
  output logic          actReq,
  output logic [2:0]    actFn,
  output logic [RW-1:0] actRowA,
  output logic [RW-1:0] actRowB,
  output logic [RW-1:0] actRowC,
  output logic [CW-1:0] actCol,
  output logic          wrSumEn,
  output logic [RW-1:0] wrSumRow,
  output logic [CW-1:0] wrSumCol,
  output logic          wrSumBit,
  output logic          wrCarryEn,
  output logic [RW-1:0] wrCarryRow,
  output logic [CW-1:0] wrCarryCol,
  output logic          wrCarryBit,
  output logic          carryOut
);

  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [RW-1:0] rowAQ, rowBQ, rowCarryQ, rowSumQ;
  logic          sumBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAQ     <= '0;
      rowBQ     <= '0;
      rowCarryQ <= '0;
      rowSumQ   <= '0;
    end else if (strobe.capture) begin
      rowAQ     <= rowA;
      rowBQ     <= rowB;
      rowCarryQ <= rowCarry;
      rowSumQ   <= rowSum;
    end
  end

  // gate array: odd parity of three bits from the sensed flags only
  assign sumBit = luAnd | (luOr & ~luMaj);

  assign actReq  = strobe.activate;
  assign actFn   = strobe.activate ? 3'b111 : 3'b000;
  assign actRowA = rowAQ;
  assign actRowB = rowBQ;
  assign actRowC = rowCarryQ;
  assign actCol  = bitIdx;

  assign wrSumEn  = strobe.writeBack;
  assign wrSumRow = rowSumQ;
  assign wrSumCol = bitIdx;
  assign wrSumBit = sumBit;

  assign wrCarryEn  = strobe.clearCarry | (strobe.writeBack & ~strobe.lastBit);
  assign wrCarryRow = rowCarryQ;
  assign wrCarryCol = strobe.clearCarry ? '0 : bitIdx + 1'b1;
  assign wrCarryBit = strobe.clearCarry ? 1'b0 : luMaj;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryOut <= 1'b0;
    end else if (strobe.capture) begin
      carryOut <= 1'b0;
    end else if (strobe.writeBack && strobe.lastBit) begin
      carryOut <= luMaj;
    end
  end

  AST_NO_CARRY_AFTER_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (wrSumEn && wrSumCol == LAST_IDX) |-> !wrCarryEn); // R4

  AST_CARRY_NEXT_COL: assert property (@(posedge clk) disable iff (!rstN)
    (wrSumEn && wrCarryEn) |-> (wrCarryCol == wrSumCol + 1'b1)); // R3

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !(wrSumEn && wrSumCol == LAST_IDX)) |=> $stable(carryOut)); // R7

  AST_ACT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    actReq |-> (!wrSumEn && !wrCarryEn)); // R1

endmodule

// File: rtl/imadd_ctrl.sv
module imadd_ctrl
  import imadd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int RW    = 4,
  parameter int LAT   = 1,
  localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW-1:0] rowA,
  input  logic [RW-1:0] rowB,
  input  logic [RW-1:0] rowCarry,
  input  logic [RW-1:0] rowSum,
  output logic          done,
  output logic          carryOut,
  output logic          actReq,
  output logic [2:0]    actFn,
  output logic [RW-1:0] actRowA,
  output logic [RW-1:0] actRowB,
  output logic [RW-1:0] actRowC,
  output logic [CW-1:0] actCol,
  input  logic          luOr,
  input  logic          luMaj,
  input  logic          luAnd,
  output logic          wrSumEn,
  output logic [RW-1:0] wrSumRow,
  output logic [CW-1:0] wrSumCol,
  output logic          wrSumBit,
  output logic          wrCarryEn,
  output logic [RW-1:0] wrCarryRow,
  output logic [CW-1:0] wrCarryCol,
  output logic          wrCarryBit
);

  ctrlStrobe_t   strobe;
  logic [CW-1:0] bitIdx;

  imadd_seq #(.WIDTH(WIDTH), .LAT(LAT)) u_seq (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .bitIdx (bitIdx),
    .done   (done)
  );

  imadd_dp #(.WIDTH(WIDTH), .RW(RW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bitIdx     (bitIdx),
    .rowA       (rowA),
    .rowB       (rowB),
    .rowCarry   (rowCarry),
    .rowSum     (rowSum),
    .luOr       (luOr),
    .luMaj      (luMaj),
    .luAnd      (luAnd),
    .actReq     (actReq),
    .actFn      (actFn),
    .actRowA    (actRowA),
    .actRowB    (actRowB),
    .actRowC    (actRowC),
    .actCol     (actCol),
    .wrSumEn    (wrSumEn),
    .wrSumRow   (wrSumRow),
    .wrSumCol   (wrSumCol),
    .wrSumBit   (wrSumBit),
    .wrCarryEn  (wrCarryEn),
    .wrCarryRow (wrCarryRow),
    .wrCarryCol (wrCarryCol),
    .wrCarryBit (wrCarryBit),
    .carryOut   (carryOut)
  );

endmodule

// File: tb/sim_imadd_ctrl.sv
module sim_memlu #(
  parameter int WIDTH = 32,
  parameter int RW    = 4,
  parameter int LAT   = 1,
  localparam int CW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             ldEn,
  input  logic [RW-1:0]    ldRow,
  input  logic [WIDTH-1:0] ldData,
  input  logic             actReq,
  input  logic [RW-1:0]    actRowA,
  input  logic [RW-1:0]    actRowB,
  input  logic [RW-1:0]    actRowC,
  input  logic [CW-1:0]    actCol,
  input  logic             wrSumEn,
  input  logic [RW-1:0]    wrSumRow,
  input  logic [CW-1:0]    wrSumCol,
  input  logic             wrSumBit,
  input  logic             wrCarryEn,
  input  logic [RW-1:0]    wrCarryRow,
  input  logic [CW-1:0]    wrCarryCol,
  input  logic             wrCarryBit,
  output logic             luOr,
  output logic             luMaj,
  output logic             luAnd
);
  logic [WIDTH-1:0] mem [1<<RW];
  logic [2:0]       pipe [LAT];
  logic a, b, c;

  assign a = mem[actRowA][actCol];
  assign b = mem[actRowB][actCol];
  assign c = mem[actRowC][actCol];
  assign {luAnd, luMaj, luOr} = pipe[LAT-1];

  initial begin
    for (int k = 0; k < (1 << RW); k++) mem[k] = '0;
    for (int k = 0; k < LAT; k++) pipe[k] = '0;
  end

  always @(posedge clk) begin
    pipe[0] <= actReq ? {a & b & c, (a & b) | (a & c) | (b & c), a | b | c} : 3'b000;
    for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    if (ldEn) mem[ldRow] <= ldData;
    if (wrSumEn) mem[wrSumRow][wrSumCol] <= wrSumBit;
    if (wrCarryEn) mem[wrCarryRow][wrCarryCol] <= wrCarryBit;
  end
endmodule

module sim_imadd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int RW = 4;
  localparam int CW = 5;
  localparam logic [RW-1:0] ROW_A = 4'd2, ROW_B = 4'd5, ROW_C = 4'd9, ROW_S = 4'd12;
  localparam logic [63:0] VEC [8] = '{
    {32'h00000000, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000001},
    {32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'hAAAAAAAA, 32'h55555555},
    {32'h12345678, 32'h9ABCDEF0},
    {32'h80000000, 32'h80000000},
    {32'h7FFFFFFF, 32'h00000001},
    {32'hDEADBEEF, 32'h0BADF00D}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // instance signals: index 0 = one-cycle logic unit, 1 = three-cycle
  logic          start0, start1, done0, done1, cOut0, cOut1;
  logic          actReq0, actReq1;
  logic [2:0]    actFn0, actFn1;
  logic [RW-1:0] aRA0, aRB0, aRC0, aRA1, aRB1, aRC1;
  logic [CW-1:0] aCol0, aCol1;
  logic          lOr0, lMaj0, lAnd0, lOr1, lMaj1, lAnd1;
  logic          sEn0, sEn1, sBit0, sBit1, cEn0, cEn1, cBit0, cBit1;
  logic [RW-1:0] sRow0, sRow1, cRow0, cRow1;
  logic [CW-1:0] sCol0, sCol1, cCol0, cCol1;
  logic          ldEn0 = 1'b0, ldEn1 = 1'b0;
  logic [RW-1:0] ldRow = '0;
  logic [N-1:0]  ldData = '0;

  imadd_ctrl #(.WIDTH(N), .RW(RW), .LAT(1)) u0 (
    .clk(clk), .rstN(rstN), .start(start0), .rowA(ROW_A), .rowB(ROW_B),
    .rowCarry(ROW_C), .rowSum(ROW_S), .done(done0), .carryOut(cOut0),
    .actReq(actReq0), .actFn(actFn0), .actRowA(aRA0), .actRowB(aRB0),
    .actRowC(aRC0), .actCol(aCol0), .luOr(lOr0), .luMaj(lMaj0), .luAnd(lAnd0),
    .wrSumEn(sEn0), .wrSumRow(sRow0), .wrSumCol(sCol0), .wrSumBit(sBit0),
    .wrCarryEn(cEn0), .wrCarryRow(cRow0), .wrCarryCol(cCol0), .wrCarryBit(cBit0));

  sim_memlu #(.WIDTH(N), .RW(RW), .LAT(1)) m0 (
    .clk(clk), .ldEn(ldEn0), .ldRow(ldRow), .ldData(ldData), .actReq(actReq0),
    .actRowA(aRA0), .actRowB(aRB0), .actRowC(aRC0), .actCol(aCol0),
    .wrSumEn(sEn0), .wrSumRow(sRow0), .wrSumCol(sCol0), .wrSumBit(sBit0),
    .wrCarryEn(cEn0), .wrCarryRow(cRow0), .wrCarryCol(cCol0), .wrCarryBit(cBit0),
    .luOr(lOr0), .luMaj(lMaj0), .luAnd(lAnd0));

  imadd_ctrl #(.WIDTH(N), .RW(RW), .LAT(3)) u1 (
    .clk(clk), .rstN(rstN), .start(start1), .rowA(ROW_A), .rowB(ROW_B),
    .rowCarry(ROW_C), .rowSum(ROW_S), .done(done1), .carryOut(cOut1),
    .actReq(actReq1), .actFn(actFn1), .actRowA(aRA1), .actRowB(aRB1),
    .actRowC(aRC1), .actCol(aCol1), .luOr(lOr1), .luMaj(lMaj1), .luAnd(lAnd1),
    .wrSumEn(sEn1), .wrSumRow(sRow1), .wrSumCol(sCol1), .wrSumBit(sBit1),
    .wrCarryEn(cEn1), .wrCarryRow(cRow1), .wrCarryCol(cCol1), .wrCarryBit(cBit1));

  sim_memlu #(.WIDTH(N), .RW(RW), .LAT(3)) m1 (
    .clk(clk), .ldEn(ldEn1), .ldRow(ldRow), .ldData(ldData), .actReq(actReq1),
    .actRowA(aRA1), .actRowB(aRB1), .actRowC(aRC1), .actCol(aCol1),
    .wrSumEn(sEn1), .wrSumRow(sRow1), .wrSumCol(sCol1), .wrSumBit(sBit1),
    .wrCarryEn(cEn1), .wrCarryRow(cRow1), .wrCarryCol(cCol1), .wrCarryBit(cBit1),
    .luOr(lOr1), .luMaj(lMaj1), .luAnd(lAnd1));

  // port monitors (cumulative counters; tasks take deltas)
  int carryWb0 = 0, clears0 = 0, actErr0 = 0, step0 = 0, wrErr0 = 0;
  int carryWb1 = 0, clears1 = 0, actErr1 = 0, step1 = 0, wrErr1 = 0;
  int actCycle0 = 0, actCycle1 = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (rstN) begin
    if (cEn0 && cCol0 == '0) begin clears0 <= clears0 + 1; step0 <= 0; end
    else if (cEn0) carryWb0 <= carryWb0 + 1;
    if (actReq0) begin
      if (aCol0 != CW'(step0) || actFn0 != 3'b111 || aRA0 != ROW_A || aRB0 != ROW_B || aRC0 != ROW_C)
        actErr0 <= actErr0 + 1;
      step0 <= step0 + 1;
      actCycle0 <= cyc;
    end
    if (sEn0 && (cyc != actCycle0 + 1 || sCol0 != CW'(step0 - 1))) wrErr0 <= wrErr0 + 1;
  end

  always @(posedge clk) if (rstN) begin
    if (cEn1 && cCol1 == '0) begin clears1 <= clears1 + 1; step1 <= 0; end
    else if (cEn1) carryWb1 <= carryWb1 + 1;
    if (actReq1) begin
      if (aCol1 != CW'(step1) || actFn1 != 3'b111 || aRA1 != ROW_A || aRB1 != ROW_B || aRC1 != ROW_C)
        actErr1 <= actErr1 + 1;
      step1 <= step1 + 1;
      actCycle1 <= cyc;
    end
    if (sEn1 && (cyc != actCycle1 + 3 || sCol1 != CW'(step1 - 1))) wrErr1 <= wrErr1 + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadRow(input bit slow, input logic [RW-1:0] row, input logic [N-1:0] data);
    @(negedge clk);
    ldRow = row; ldData = data;
    if (slow) ldEn1 = 1'b1; else ldEn0 = 1'b1;
    @(negedge clk);
    ldEn0 = 1'b0; ldEn1 = 1'b0;
  endtask

  task automatic runAdd(input bit slow, input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
    int cnt, lat, wb0, cl0, ae0, we0;
    bit seen;
    logic [63:0] full;
    logic [N-1:0] expCarryRow, sumRow, carryRow;
    logic cOut;
    lat = slow ? 3 : 1;
    loadRow(slow, ROW_A, a);
    loadRow(slow, ROW_B, b);
    loadRow(slow, ROW_C, '1);
    loadRow(slow, ROW_S, '1);
    wb0 = slow ? carryWb1 : carryWb0;
    cl0 = slow ? clears1 : clears0;
    ae0 = slow ? actErr1 : actErr0;
    we0 = slow ? wrErr1 : wrErr0;
    if (slow) start1 = 1'b1; else start0 = 1'b1;
    cnt = 0; seen = 1'b0;
    while (!seen && cnt < 2000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (slow) start1 = (poke && cnt == 8); else start0 = (poke && cnt == 8);
      seen = slow ? done1 : done0;
    end
    full = {32'b0, a} + {32'b0, b};
    expCarryRow[0] = 1'b0;
    for (int i = 1; i < N; i++) begin
      logic [63:0] msk;
      msk = (64'd1 << i) - 1;
      expCarryRow[i] = (((({32'b0, a} & msk) + ({32'b0, b} & msk)) >> i) & 64'd1) != 0;
    end
    sumRow   = slow ? m1.mem[ROW_S] : m0.mem[ROW_S];
    carryRow = slow ? m1.mem[ROW_C] : m0.mem[ROW_C];
    cOut     = slow ? cOut1 : cOut0;
    check(cnt == 2 + N * (lat + 1), poke ? "R8" : "R7", "cycles to done",
          64'(cnt), 64'(2 + N * (lat + 1)));
    check(sumRow == full[N-1:0], "R10", "sum row", {32'b0, sumRow}, {32'b0, full[N-1:0]});
    check(sumRow == (a ^ b ^ expCarryRow), "R2", "sum bits as parity", {32'b0, sumRow},
          {32'b0, a ^ b ^ expCarryRow});
    check(cOut == full[N], "R10", "carryOut", 64'(cOut), 64'(full[N]));
    check(carryRow == expCarryRow, "R3", "carry row contents", {32'b0, carryRow}, {32'b0, expCarryRow});
    check(((slow ? carryWb1 : carryWb0) - wb0) == N - 1, "R4", "carry write-backs",
          64'((slow ? carryWb1 : carryWb0) - wb0), 64'(N - 1));
    check(((slow ? clears1 : clears0) - cl0) == 1 && carryRow[0] == 1'b0, "R5", "column-0 clear",
          64'((slow ? clears1 : clears0) - cl0), 64'd1);
    check(((slow ? actErr1 : actErr0) - ae0) == 0, "R1", "activation fields",
          64'((slow ? actErr1 : actErr0) - ae0), 64'd0);
    check(((slow ? wrErr1 : wrErr0) - we0) == 0, "R6", "write timing after activation",
          64'((slow ? wrErr1 : wrErr0) - we0), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check((slow ? done1 : done0) == 1'b0, "R7", "done pulse width", 64'(slow ? done1 : done0), 64'd0);
  endtask

  initial begin
    start0 = 1'b0; start1 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(done0 == 0 && done1 == 0, "R9", "done in reset", 64'(done0 | done1), 64'd0);
    check(actReq0 == 0 && actReq1 == 0, "R9", "actReq in reset", 64'(actReq0 | actReq1), 64'd0);
    check(!sEn0 && !cEn0 && !sEn1 && !cEn1, "R9", "write enables in reset",
          64'({sEn0, cEn0, sEn1, cEn1}), 64'd0);
    check(cOut0 == 0 && cOut1 == 0, "R9", "carryOut in reset", 64'(cOut0 | cOut1), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) runAdd(1'b0, VEC[k][63:32], VEC[k][31:0], 1'b0);

    // slower logic unit: four cycles per bit
    runAdd(1'b1, 32'hFFFFFFFF, 32'h00000001, 1'b0);
    runAdd(1'b1, 32'h13579BDF, 32'h2468ACE0, 1'b0);

    // R8: start pulsed mid-run is ignored
    runAdd(1'b0, 32'hFFFF0000, 32'h0001FFFF, 1'b1);

    // R7: final carry held while idle
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(cOut0 == 1'b1, "R7", "carryOut held while idle", 64'(cOut0), 64'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule